// File: doc/BRIEF.md
# Serial Byte Receiver with Parity Capture

This block turns an asynchronous serial line into bytes. A frame opens with a low start bit. Eight data bits follow, least significant first, then one parity bit and a high stop bit. The transmitter sets the parity bit so that the data bits and the parity bit together hold an even number of ones. The block compares nothing: it passes the received parity bit on, and logic further down the path judges it.

Timing comes from a sampling tick input. Some outside divider of the system clock produces this tick, which is high for one clock cycle per sampling interval. The parameter `OVS` sets how many ticks make one bit period. In service it is 16 ticks per bit, with a 50 MHz clock divided by 163, which is close to 19200 baud. For simulation a short setting of 4 ticks with a divide-by-3 tick source is used.

The line first passes through a synchroniser. The block then looks for a falling edge and confirms the start bit half a bit period later. After that it samples each following bit one full bit period after the previous sample point. When the stop bit period is complete, it presents the byte and the parity bit together with a done pulse that lasts one cycle.

Top module: `uart_par_rx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `done_o` is 0, `data_o` is 0x00 and `par_o` is 0.
- R2: A frame carries a low start bit, 8 data bits with bit 0 first, a parity bit and a stop bit, each lasting `OVS` ticks. For each such frame, `data_o` shows the 8 data bits with the first received bit at bit 0, and this value is valid in the cycle where `done_o` is high.
- R3: `par_o` shows the level of the bit that follows the 8th data bit, as it was received, whether or not it gives even parity. It is valid together with `done_o`.
- R4: `done_o` is high for exactly one cycle, and exactly once for each accepted frame.
- R5: A low pulse on the line counts as a start bit only if the line is still low `OVS/2` ticks after the falling edge. A shorter low pulse makes no `done_o`, and the next frame is received correctly.
- R6: `done_o` is raised when the stop bit period ends, even if the line is low at that point. Frames that follow are still received correctly.
- R7: `data_o` and `par_o` change only in a cycle where `done_o` is high.
- R8: The receiver moves forward only on cycles where `tick_i` is high. `done_o` only rises in the cycle after a tick, and while no ticks arrive a frame produces no `done_o`.
- R9: Samples are spaced by the parameter `OVS`, which must be even and at least 2. The bit-period counter never reaches `OVS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, high for one cycle per sampling interval |
| rx_i | input | 1 | Serial line, idle high, asynchronous to `clk` |
| data_o | output | DATA_W | Byte from the last completed frame |
| par_o | output | 1 | Parity bit received with that byte |
| done_o | output | 1 | One-cycle pulse when a frame has completed |

## Verification
Two events can fall on neighbouring cycles. One is the end of a frame, where `done_o` fires and the receiver goes back to idle. The other is a falling edge on the line, which the idle state could take as a new start bit. The bench provokes this in two ways. It sends frames with no idle gap between them. It also sends frames whose stop bit is held low past the end-of-frame sample and then released. In each case the check passes only if every frame gives exactly one `done_o` with the right byte and parity bit, and no extra frame is decoded from the low stop level. Short low glitches and a period with the tick held off also check that no `done_o` appears that should not.

// File: rtl/uprx_pkg.sv
package uprx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } rx_state_e;

endpackage

// File: rtl/uprx_sync.sv
module uprx_sync #(
   parameter int STAGES  = 2,
   parameter bit IDLE_LV = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("uprx_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= IDLE_LV;
            else        chain <= d_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{IDLE_LV}};
            else        chain <= {chain[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/uprx_bitclk.sv
module uprx_bitclk #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic clr_i,
   output logic half_o,
   output logic full_o
);

   localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
   localparam int HALF  = OVS / 2;

   generate
      if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("uprx_bitclk: OVS must be even and at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             at_last;

   assign at_last = (cnt == CNT_W'(OVS - 1));
   assign half_o  = tick_i && (cnt == CNT_W'(HALF - 1));
   assign full_o  = tick_i && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr_i) begin
         cnt <= '0;
      end else if (tick_i) begin
         cnt <= at_last ? '0 : cnt + 1'b1;
      end
   end

   // R9: the bit-period counter stays below OVS
   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) < OVS);

   // R8: without a tick and without a clear the count holds
   p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clr_i) |=> $stable(cnt));

endmodule

// File: rtl/uprx_shreg.sv
module uprx_shreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_i,
   input  logic         bit_i,
   output logic [W-1:0] q_o
);

   generate
      if (W < 2) begin : g_bad_w
         $error("uprx_shreg: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_o <= '0;
      else if (shift_i) q_o <= {bit_i, q_o[W-1:1]};
   end

endmodule

// File: rtl/uart_par_rx.sv
module uart_par_rx #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rx_i,
   output logic [DATA_W-1:0] data_o,
   output logic              par_o,
   output logic              done_o
);

   import uprx_pkg::*;

   localparam int NB_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   generate
      if (DATA_W < 2) begin : g_bad_dw
         $error("uart_par_rx: DATA_W must be at least 2");
      end
   endgenerate

   rx_state_e         state, nxt;
   logic              rx_s;
   logic              half_t, full_t;
   logic              clr, shift, cap_par, fin;
   logic [NB_W-1:0]   nbit;
   logic              par_raw;
   logic [DATA_W-1:0] shv;

   uprx_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_i),
      .q_o   (rx_s)
   );

   uprx_bitclk #(.OVS(OVS)) u_bitclk (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .clr_i  (clr),
      .half_o (half_t),
      .full_o (full_t)
   );

   uprx_shreg #(.W(DATA_W)) u_shreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (shift),
      .bit_i   (rx_s),
      .q_o     (shv)
   );

   always_comb begin
      nxt     = state;
      clr     = 1'b0;
      shift   = 1'b0;
      cap_par = 1'b0;
      fin     = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (!rx_s) begin
               nxt = ST_START;
               clr = 1'b1;
            end
         end
         ST_START: begin
            if (half_t) begin
               clr = 1'b1;
               nxt = rx_s ? ST_IDLE : ST_DATA;
            end
         end
         ST_DATA: begin
            if (full_t) begin
               shift = 1'b1;
               if (nbit == NB_W'(DATA_W - 1)) nxt = ST_PAR;
            end
         end
         ST_PAR: begin
            if (full_t) begin
               cap_par = 1'b1;
               nxt     = ST_STOP;
            end
         end
         ST_STOP: begin
            if (full_t) begin
               fin = 1'b1;
               nxt = ST_IDLE;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         nbit    <= '0;
         par_raw <= 1'b0;
         data_o  <= '0;
         par_o   <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         state  <= nxt;
         done_o <= fin;
         if (clr)          nbit    <= '0;
         else if (shift)   nbit    <= nbit + 1'b1;
         if (cap_par)      par_raw <= rx_s;
         if (fin) begin
            data_o <= shv;
            par_o  <= par_raw;
         end
      end
   end

   // R4: the completion pulse never lasts two cycles
   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7: outputs move only together with the completion pulse
   p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(data_o) && $stable(par_o)));

   // R8: a completion is always paced by a tick
   p_done_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(tick_i));

   // R5: leaving idle requires the synchronised line to have been low
   p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START && $past(state) == ST_IDLE) |-> $past(!rx_s));

endmodule

// File: tb/uart_par_rx_tb.sv
module uart_par_rx_tb;

   localparam int OVS  = 4;
   localparam int DIV  = 3;
   localparam int BITC = OVS * DIV;

   logic       clk;
   logic       rst_n;
   logic       tick;
   logic       rx;
   logic [7:0] data_o;
   logic       par_o;
   logic       done_o;

   int  checks;
   int  bad;
   int  n_sent;
   int  n_got;
   int  tdiv;
   int  hold_errs;
   bit  tick_en;
   bit  finished;
   bit  prev_done;
   logic [7:0] last_d;
   logic       last_p;
   logic [7:0] exp_d [0:255];
   bit         exp_p [0:255];

   uart_par_rx #(.DATA_W(8), .OVS(OVS), .SYNC_STAGES(2)) u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .rx_i   (rx),
      .data_o (data_o),
      .par_o  (par_o),
      .done_o (done_o)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   function automatic bit even_par(input logic [7:0] d);
      return ^d;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   endtask

   // tick source: divide by DIV, gated by tick_en
   initial begin
      tdiv = 0;
      tick = 1'b0;
      forever begin
         @(negedge clk);
         tdiv = (tdiv == DIV - 1) ? 0 : tdiv + 1;
         tick = tick_en && (tdiv == 0);
      end
   end

   // output monitor
   initial begin
      prev_done = 1'b0;
      last_d    = 8'h00;
      last_p    = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (done_o) begin
               chk(!prev_done, "R4 done width", 1, 0);
               chk(n_got < n_sent, "R4 unexpected done", n_got, n_sent);
               if (n_got < n_sent) begin
                  chk(data_o == exp_d[n_got], "R2 data", data_o, exp_d[n_got]);
                  chk(par_o == exp_p[n_got], "R3 parity", par_o, exp_p[n_got]);
                  n_got++;
               end
            end else if (data_o !== last_d || par_o !== last_p) begin
               hold_errs++;
            end
            last_d    = data_o;
            last_p    = par_o;
            prev_done = done_o;
         end
      end
   end

   task automatic line(input logic b, input int clocks);
      rx = b;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input bit p, input int stop_low, input bit expect_it);
      if (expect_it) begin
         exp_d[n_sent] = d;
         exp_p[n_sent] = p;
         n_sent++;
      end
      line(1'b0, BITC);
      for (int i = 0; i < 8; i++) line(d[i], BITC);
      line(p, BITC);
      if (stop_low > 0) begin
         line(1'b0, stop_low);
         line(1'b1, BITC - stop_low);
      end else begin
         line(1'b1, BITC);
      end
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      bad++;
      $display("FAIL watchdog actual=expired expected=finish");
      summary();
   end

   initial begin
      logic [7:0] rb;
      bit         rp;
      void'($urandom(32'd2718));
      checks = 0; bad = 0; n_sent = 0; n_got = 0; hold_errs = 0;
      finished = 1'b0;
      tick_en  = 1'b1;
      rx       = 1'b1;
      rst_n    = 1'b0;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk(done_o == 1'b0, "R1 done", done_o, 0);
      chk(data_o == 8'h00, "R1 data", data_o, 0);
      chk(par_o == 1'b0, "R1 parity", par_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done_o == 1'b0 && data_o == 8'h00, "R1 after release", data_o, 0);
      line(1'b1, 2 * BITC);

      // R2/R3 directed bytes
      send_frame(8'h41, even_par(8'h41), 0, 1'b1);
      line(1'b1, BITC);
      send_frame(8'h43, even_par(8'h43), 0, 1'b1);
      line(1'b1, BITC);
      send_frame(8'h00, even_par(8'h00), 0, 1'b1);
      send_frame(8'hFF, even_par(8'hFF), 0, 1'b1);
      line(1'b1, BITC);
      // R3: wrong parity passed through unchanged
      send_frame(8'h41, 1'b1, 0, 1'b1);
      line(1'b1, 2 * BITC);
      chk(n_got == n_sent, "R2 directed count", n_got, n_sent);

      // R5: short glitch below half a bit
      line(1'b0, 3);
      line(1'b1, 4 * BITC);
      chk(n_got == n_sent, "R5 glitch ignored", n_got, n_sent);
      send_frame(8'hA5, even_par(8'hA5), 0, 1'b1);
      line(1'b1, 2 * BITC);
      chk(n_got == n_sent, "R5 frame after glitch", n_got, n_sent);

      // R6: stop level low at its sample point
      send_frame(8'h5A, even_par(8'h5A), 9, 1'b1);
      line(1'b1, 3 * BITC);
      chk(n_got == n_sent, "R6 low stop completes once", n_got, n_sent);
      send_frame(8'h3C, even_par(8'h3C), 0, 1'b1);
      line(1'b1, 2 * BITC);
      chk(n_got == n_sent, "R6 frame after low stop", n_got, n_sent);

      // R8: no ticks, no progress
      tick_en = 1'b0;
      send_frame(8'h81, even_par(8'h81), 0, 1'b0);
      line(1'b1, BITC);
      chk(n_got == n_sent && data_o == 8'h3C, "R8 frozen without tick", data_o, 8'h3C);
      tick_en = 1'b1;
      line(1'b1, 4 * BITC);
      chk(n_got == n_sent, "R8 no stray done", n_got, n_sent);

      // random frames, back to back or with gaps, R9 spacing at OVS
      for (int k = 0; k < 40; k++) begin
         rb = 8'($urandom);
         rp = even_par(rb);
         if ($urandom % 4 == 0) rp = ~rp;
         send_frame(rb, rp, 0, 1'b1);
         line(1'b1, $urandom % 20);
      end
      line(1'b1, 3 * BITC);
      chk(n_got == n_sent, "R9 random frames all decoded", n_got, n_sent);
      chk(hold_errs == 0, "R7 outputs held between pulses", hold_errs, 0);
      summary();
   end

endmodule